// File: doc/BRIEF.md
# Double-Buffered SPI Master

This block is a byte-wide SPI master that a host drives through a small register bus. A transmit byte written by the host waits in a holding slot while the byte ahead of it is shifted out. When that byte ends, the held byte starts on the next serial clock period with no idle time between them. Every received byte goes into a two-entry queue that the host drains by reading. Each completed byte raises a sticky ready event, which the host polls and clears with a write. This lets a processor stream a sensor's buffer at full serial rate without using interrupts.

The link runs in SPI mode 0, most significant bit first. The serial clock rate is set by a divider register. Chip select is not generated here: the host drives it from a general-purpose output and releases it once the busy output has dropped. A typical register read sends a command byte with bit 7 set and then 0xFF filler bytes. The byte that returns during the command is read and thrown away.

Top module: `spiDbufMaster`

## Requirements
- R1: The transmit data register (address 0, write) accepts a second byte while a byte is shifting. The held byte starts on the next serial clock period, so successive SCK rising edges within a burst are exactly 2×(DIV+1) clock cycles apart with no gap between bytes.
- R2: Mode 0, MSB first. SCK idles low. MOSI carries bit 7 first and changes only when SCK falls or a byte is loaded, never when SCK rises. MISO is sampled when SCK rises and assembled MSB first.
- R3: Each SCK half-period lasts DIV+1 clock cycles. DIV is the 8-bit register at address 4, readable, with reset value 0.
- R4: Reading address 1 returns the oldest received byte and removes it from the two-entry receive queue. Reading it while the queue is empty returns 0x00 and changes nothing.
- R5: The event register (address 2, bit 0) is set when a byte completes. It stays set until a write to address 2 with bit 0 = 0. A write with bit 0 = 1 leaves it unchanged. If a completion and a clearing write fall in the same cycle, the flag ends set.
- R6: A write to address 0 while the holding slot is full and is not being emptied in that cycle is discarded and never transmitted. It sets status bit 0 (address 3). Status bits are cleared only by writing 1 to them at address 3.
- R7: A byte that completes while both receive entries are unread, with no read in that cycle, is discarded and sets status bit 1 (address 3).
- R8: `busy` rises the cycle after a write to address 0. It stays high until the holding slot is empty and the final bit period has ended, and it never drops in the middle of a byte.
- R9: After reset, SCK is low, `busy` is low, the event flag and both status bits are 0, and the receive queue is empty.
- R10: A burst of N bytes produces exactly 8×N SCK rising edges; a three-byte register read produces 24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (pops the receive queue at address 1) |
| busAddr | input | 3 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of the access |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress or byte queued |

## Verification
The event flag can be set by a byte completing and cleared by a host write in the same clock cycle. The bench provokes this on purpose. With DIV = 3 it queues two bytes and counts SCK rising edges up to the sixteenth. It then waits exactly DIV clock cycles, so that a clearing write to address 2 lands in the cycle in which the second byte finishes. A read of the flag afterwards must show it still set. A clear issued a cycle later must then show it at 0.

// File: rtl/spiDbufPkg.sv
package spiDbufPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_TX   = 3'd0;
  localparam logic [ADDR_W-1:0] REG_RX   = 3'd1;
  localparam logic [ADDR_W-1:0] REG_EVT  = 3'd2;
  localparam logic [ADDR_W-1:0] REG_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] REG_DIV  = 3'd4;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // move held byte into the shifter
    logic shift;   // advance MOSI on a falling SCK
    logic sample;  // capture MISO on a rising SCK
    logic done;    // byte finished on this edge
  } spiStrobe_t;
endpackage

// File: rtl/spiByteFifo.sv
module spiByteFifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic             dropped
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign doPop   = pop && !empty;
  assign doPush  = push && (!full || doPop);
  assign dropped = push && !doPush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (doPush && !doPop) count <= count + 1'b1;
    else if (doPop && !doPush) count <= count - 1'b1;
  end

  generate
    if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] slot;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) slot <= '0;
        else if (doPush) slot <= din;
      end
      assign dout = slot;
    end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      logic [WIDTH-1:0] mem [DEPTH];
      logic [PTR_W-1:0] rdPtr, wrPtr;

      function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
      endfunction

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rdPtr <= '0;
          wrPtr <= '0;
        end else begin
          if (doPush) wrPtr <= bump(wrPtr);
          if (doPop)  rdPtr <= bump(rdPtr);
        end
      end

      always_ff @(posedge clk) begin
        if (doPush) mem[wrPtr] <= din;
      end

      assign dout = empty ? '0 : mem[rdPtr];
    end
  endgenerate
endmodule

// File: rtl/spiCtrl.sv
module spiCtrl
  import spiDbufPkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txAvail,
  input  logic [DIV_W-1:0] divVal,
  output logic             sck,
  output logic             active,
  output spiStrobe_t       strobe
);
  localparam int BIT_W = $clog2(BYTE_W);

  typedef enum logic {S_IDLE, S_RUN} ctlState_t;

  ctlState_t        state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             tick, lastBit;

  assign active  = (state == S_RUN);
  assign tick    = active && (divCnt >= divVal);
  assign lastBit = (bitCnt == BIT_W'(BYTE_W - 1));

  always_comb begin
    strobe        = '0;
    strobe.sample = tick && !sck;
    strobe.shift  = tick && sck && !lastBit;
    strobe.done   = tick && sck && lastBit;
    strobe.load   = (!active && txAvail) || (strobe.done && txAvail);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      divCnt <= '0;
      bitCnt <= '0;
      sck    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          divCnt <= '0;
          bitCnt <= '0;
          sck    <= 1'b0;
          if (txAvail) state <= S_RUN;
        end
        S_RUN: begin
          if (tick) begin
            divCnt <= '0;
            if (!sck) begin
              sck <= 1'b1;
            end else begin
              sck <= 1'b0;
              if (lastBit) begin
                bitCnt <= '0;
                if (!txAvail) state <= S_IDLE;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spiDatapath.sv
module spiDatapath
  import spiDbufPkg::*;
#(
  parameter int              DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = '0,
  parameter int              TX_HOLD   = 1,
  parameter int              RX_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  input  logic              miso,
  output logic              mosi,
  input  spiStrobe_t        strobe,
  output logic              txAvail,
  output logic [DIV_W-1:0]  divVal,
  output logic              evtFlag,
  output logic [1:0]        statFlags
);
  logic [BYTE_W-1:0] holdOut, rxOut, txShift, rxShift;
  logic holdFull, holdEmpty, holdDrop;
  logic rxFull, rxEmpty, rxDrop;
  logic wrTx, wrEvt, wrStat, wrDiv, rdRx;

  assign wrTx   = busWr && (busAddr == REG_TX);
  assign wrEvt  = busWr && (busAddr == REG_EVT);
  assign wrStat = busWr && (busAddr == REG_STAT);
  assign wrDiv  = busWr && (busAddr == REG_DIV);
  assign rdRx   = busRd && (busAddr == REG_RX);

  spiByteFifo #(.WIDTH(BYTE_W), .DEPTH(TX_HOLD)) u_hold (
    .clk(clk), .rstN(rstN), .push(wrTx), .pop(strobe.load), .din(busWdata),
    .dout(holdOut), .full(holdFull), .empty(holdEmpty), .dropped(holdDrop)
  );

  spiByteFifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .push(strobe.done), .pop(rdRx), .din(rxShift),
    .dout(rxOut), .full(rxFull), .empty(rxEmpty), .dropped(rxDrop)
  );

  assign txAvail = !holdEmpty;
  assign mosi    = txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (strobe.load)       txShift <= holdOut;
      else if (strobe.shift) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strobe.sample)     rxShift <= {rxShift[BYTE_W-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtFlag   <= 1'b0;
      statFlags <= '0;
      divVal    <= DIV_RESET;
    end else begin
      if (strobe.done)                 evtFlag <= 1'b1;
      else if (wrEvt && !busWdata[0])  evtFlag <= 1'b0;

      if (holdDrop)                     statFlags[0] <= 1'b1;
      else if (wrStat && busWdata[0])   statFlags[0] <= 1'b0;

      if (rxDrop)                       statFlags[1] <= 1'b1;
      else if (wrStat && busWdata[1])   statFlags[1] <= 1'b0;

      if (wrDiv) divVal <= DIV_W'(busWdata);
    end
  end

  always_comb begin
    case (busAddr)
      REG_RX:   busRdata = rxOut;
      REG_EVT:  busRdata = {{(BYTE_W-1){1'b0}}, evtFlag};
      REG_STAT: busRdata = {{(BYTE_W-2){1'b0}}, statFlags};
      REG_DIV:  busRdata = BYTE_W'(divVal);
      default:  busRdata = '0;
    endcase
  end

  logic unusedFlags;
  assign unusedFlags = holdFull ^ rxFull ^ rxEmpty;
endmodule

// File: rtl/spiDbufMaster.sv
module spiDbufMaster
  import spiDbufPkg::*;
#(
  parameter int              DIV_W     = 8,
  parameter logic [DIV_W-1:0] DIV_RESET = '0,
  parameter int              TX_HOLD   = 1,
  parameter int              RX_DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWdata,
  output logic [BYTE_W-1:0] busRdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              busy
);
  spiStrobe_t       strobe;
  logic             txAvail, active, evtFlag;
  logic [DIV_W-1:0] divVal;
  logic [1:0]       statFlags;

  spiCtrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txAvail(txAvail), .divVal(divVal),
    .sck(sck), .active(active), .strobe(strobe)
  );

  spiDatapath #(
    .DIV_W(DIV_W), .DIV_RESET(DIV_RESET), .TX_HOLD(TX_HOLD), .RX_DEPTH(RX_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .miso(miso), .mosi(mosi),
    .strobe(strobe), .txAvail(txAvail), .divVal(divVal), .evtFlag(evtFlag),
    .statFlags(statFlags)
  );

  assign busy = active || txAvail;
endmodule

// File: rtl/spiDbufChecker.sv
module spiDbufChecker #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sck,
  input logic             mosi,
  input logic             busy,
  input logic             busWr,
  input logic [2:0]       busAddr,
  input logic             wd0,
  input logic             wd1,
  input logic [DIV_W-1:0] divVal,
  input logic             evtFlag,
  input logic [1:0]       statFlags
);
  logic [DIV_W:0] hiCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    hiCnt <= '0;
    else if (sck) hiCnt <= hiCnt + 1'b1;
    else          hiCnt <= '0;
  end

  assert_sck_high_time_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sck) |-> (hiCnt == {1'b0, divVal} + 1'b1));

  assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> $stable(mosi));

  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sck);

  assert_event_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (evtFlag && !(busWr && busAddr == 3'd2 && !wd0)) |=> evtFlag);

  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statFlags[0] && !(busWr && busAddr == 3'd3 && wd0)) |=> statFlags[0]);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statFlags[1] && !(busWr && busAddr == 3'd3 && wd1)) |=> statFlags[1]);

  assert_busy_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 3'd0) |=> busy);
endmodule

bind spiDbufMaster spiDbufChecker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rstN(rstN), .sck(sck), .mosi(mosi), .busy(busy),
  .busWr(busWr), .busAddr(busAddr), .wd0(busWdata[0]), .wd1(busWdata[1]),
  .divVal(divVal), .evtFlag(evtFlag), .statFlags(statFlags)
);

// File: tb/spiDbufMaster_bench.sv
`timescale 1ns/1ps
module spiDbufMaster_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       sck, mosi, busy;
  logic       miso = 1'b0;

  spiDbufMaster u_spiDbufMaster (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy)
  );

  always #2 clk = ~clk;

  int nChecks = 0, nFails = 0;
  int cyc = 0, curDiv = 0;
  bit finished = 0;
  logic [7:0] mosiExpQ [$];
  logic [7:0] rxSentQ [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // ---------- serial slave model / scoreboard ----------
  function automatic logic [7:0] slvPattern(input int k);
    return 8'h3C ^ 8'(k * 37);
  endfunction

  int slvIdx = 0, slvBit = 0, slvBytes = 0, riseCnt = 0, prevRise = 0, gapErr = 0;
  bit inBurst = 0, fresh = 0;
  logic [7:0] slvCur, slvOut, slvIn = '0;
  initial begin
    slvCur = slvPattern(0);
    slvOut = slvCur;
    miso   = slvOut[7];
  end

  always @(posedge sck) begin
    riseCnt++;
    if (inBurst && (cyc - prevRise) != 2 * (curDiv + 1)) gapErr++;
    prevRise = cyc;
    inBurst  = 1;
    slvIn = {slvIn[6:0], mosi};
    slvBit++;
    if (slvBit == 8) begin
      slvBit = 0;
      slvBytes++;
      if (mosiExpQ.size() == 0) check(0, "R6 byte sent that should be dropped", slvIn, 0);
      else begin
        logic [7:0] e;
        e = mosiExpQ.pop_front();
        check(slvIn == e, "R2 MOSI byte MSB first", slvIn, e);
      end
      rxSentQ.push_back(slvCur);
      slvIdx++;
      slvCur = slvPattern(slvIdx);
      slvOut = slvCur;
      miso   = slvOut[7];
      fresh  = 1;
    end
  end

  always @(negedge sck) begin
    if (fresh) fresh = 0;
    else begin
      slvOut = slvOut << 1;
      miso   = slvOut[7];
    end
  end

  always @(negedge busy) begin
    if (rstN) check(slvBit == 0, "R8 busy dropped mid-byte", slvBit, 0);
    inBurst = 0;
  end

  // ---------- host driver tasks (start and end just after a falling clk) ----------
  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] v);
    busRd = 1; busAddr = a;
    #1 v = busRdata;
    @(negedge clk);
    busRd = 0;
  endtask

  task automatic writeTx(input logic [7:0] b, input bit accepted);
    if (accepted) mosiExpQ.push_back(b);
    busWrite(3'd0, b);
  endtask

  task automatic readRx(input string tag);
    logic [7:0] v, e;
    busRead(3'd1, v);
    e = (rxSentQ.size() != 0) ? rxSentQ.pop_front() : 8'h00;
    check(v == e, tag, v, e);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic waitEvt();
    logic [7:0] v;
    do busRead(3'd2, v); while (!v[0]);
  endtask

  task automatic setDiv(input int d);
    logic [7:0] v;
    busWrite(3'd4, 8'(d));
    curDiv = d;
    busRead(3'd4, v);
    check(v == 8'(d), "R3 divider readback", v, d);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish();
  end

  initial begin
    logic [7:0] v;
    int base, bytes0;
    repeat (5) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R9 reset state
    check(sck == 0, "R9 sck low after reset", sck, 0);
    check(busy == 0, "R9 busy low after reset", busy, 0);
    busRead(3'd2, v); check(v == 0, "R9 event clear after reset", v, 0);
    busRead(3'd3, v); check(v == 0, "R9 status clear after reset", v, 0);
    busRead(3'd1, v); check(v == 0, "R4 empty queue reads zero", v, 0);
    busRead(3'd4, v); check(v == 0, "R3 divider resets to zero", v, 0);

    // single byte, DIV=0
    base = riseCnt;
    writeTx(8'h5A, 1);
    check(busy == 1, "R8 busy after TX write", busy, 1);
    waitIdle();
    check(riseCnt - base == 8, "R10 eight edges per byte", riseCnt - base, 8);
    busRead(3'd2, v); check(v[0] == 1, "R5 event set on completion", v, 1);
    readRx("R4 RX returns received byte");
    busRead(3'd1, v); check(v == 0, "R4 queue empty after pop", v, 0);
    busWrite(3'd2, 8'h00);
    busRead(3'd2, v); check(v[0] == 0, "R5 event cleared by zero write", v, 0);

    // three-byte register read at DIV=3
    setDiv(3);
    base = riseCnt;
    writeTx(8'h80 | 8'h12, 1);
    writeTx(8'hFF, 1);
    waitEvt(); busWrite(3'd2, 8'h00);
    readRx("R4 command-phase byte");
    writeTx(8'hFF, 1);
    waitEvt(); busWrite(3'd2, 8'h00);
    readRx("R4 first data byte");
    waitEvt(); busWrite(3'd2, 8'h00);
    readRx("R4 second data byte");
    waitIdle();
    check(riseCnt - base == 24, "R10 three-byte read is 24 edges", riseCnt - base, 24);
    check(gapErr == 0, "R1 no gap between queued bytes", gapErr, 0);

    // sticky event
    writeTx(8'hC3, 1);
    waitIdle();
    repeat (30) @(negedge clk);
    busRead(3'd2, v); check(v[0] == 1, "R5 event stays set", v, 1);
    busWrite(3'd2, 8'h01);
    busRead(3'd2, v); check(v[0] == 1, "R5 write of one ignored", v, 1);
    busWrite(3'd2, 8'h00);
    readRx("R4 RX after sticky test");

    // overflow at DIV=0
    setDiv(0);
    bytes0 = slvBytes;
    writeTx(8'h11, 1);
    writeTx(8'h22, 1);
    writeTx(8'h33, 0);
    waitIdle();
    check(slvBytes - bytes0 == 2, "R6 third write not sent", slvBytes - bytes0, 2);
    busRead(3'd3, v); check(v[0] == 1, "R6 overflow flag set", v, 1);
    busWrite(3'd3, 8'h00);
    busRead(3'd3, v); check(v[0] == 1, "R6 zero write keeps flag", v, 1);
    busWrite(3'd3, 8'h01);
    busRead(3'd3, v); check(v[0] == 0, "R6 one write clears flag", v, 0);
    readRx("R4 overflow byte 1");
    readRx("R4 overflow byte 2");
    busWrite(3'd2, 8'h00);

    // overrun
    writeTx(8'hA1, 1);
    writeTx(8'hA2, 1);
    waitEvt();
    writeTx(8'hA3, 1);
    waitIdle();
    busRead(3'd3, v); check(v[1] == 1, "R7 overrun flag set", v, 2);
    readRx("R7 oldest kept");
    readRx("R7 second kept");
    void'(rxSentQ.pop_front());
    busRead(3'd1, v); check(v == 0, "R7 third byte dropped", v, 0);
    busWrite(3'd3, 8'h02);
    busRead(3'd3, v); check(v == 0, "R7 overrun cleared", v, 0);
    busWrite(3'd2, 8'h00);

    // set and clear in one cycle, DIV=3
    setDiv(3);
    writeTx(8'h69, 1);
    writeTx(8'h96, 1);
    repeat (16) @(posedge sck);
    repeat (3) @(posedge clk);
    @(negedge clk);
    busWrite(3'd2, 8'h00);
    busRead(3'd2, v); check(v[0] == 1, "R5 completion wins over clear", v, 1);
    busWrite(3'd2, 8'h00);
    busRead(3'd2, v); check(v[0] == 0, "R5 later clear takes effect", v, 0);
    waitIdle();
    readRx("R4 collision byte 1");
    readRx("R4 collision byte 2");

    // another divider
    setDiv(5);
    base = riseCnt;
    writeTx(8'h0F, 1);
    writeTx(8'hF0, 1);
    waitIdle();
    check(riseCnt - base == 16, "R10 two-byte burst edges", riseCnt - base, 16);
    check(gapErr == 0, "R3 edge spacing matches divider", gapErr, 0);
    readRx("R4 div5 byte 1");
    readRx("R4 div5 byte 2");
    check(mosiExpQ.size() == 0, "R1 all queued bytes sent", mosiExpQ.size(), 0);

    repeat (5) @(negedge clk);
    finish();
  end
endmodule